// File: doc/BRIEF.md
# Configuration Completion Status Handler

This block sits in a root-port style bridge, between a host-side port that issues configuration reads and writes and the link-side path that returns completions. A host request carries a dword offset, a byte offset within the dword and an access size. The block launches the request toward the link, then waits for a completion or for a programmable timeout. When the completion arrives, the block decodes its status field and its error flag. It then gives the host one of four outcomes: pass with returned data, pass with fabricated data, fail, or an internal re-issue of the request.

The result of an Unsupported Request depends on direction. A read succeeds and returns all-ones data, while a write fails. A Configuration Retry completion is treated differently again. When retry visibility is enabled and the read covers both Vendor ID bytes, the block returns the reserved Vendor ID value. In every other case the block re-issues the request, up to a configurable number of times. After a timeout the link request is still outstanding. Until the late completion arrives, every new host request is answered at once without being launched.

Top module: `cfg_cpl_handler`

## Requirements
- R1: After reset, `done`, `pass`, `lnk_launch`, `reason` and `rdata` are all zero.
- R2: A request accepted while idle raises `lnk_launch` for one cycle, in the cycle after `req_valid`. In that cycle `lnk_dw` and `lnk_write` carry the request. `lnk_be` is `1<<lo` for size code 00 (byte), `3<<lo` truncated to 4 bits for size code 01 (halfword), and `1111` for size code 1x (dword).
- R3: The completion status code is bits 9:7 of the status word and the error flag is bit 11. Code 000 with the flag clear passes with reason 00 (OK). Code 000 with the flag set fails with reason 11 (other).
- R4: Code 001 (Unsupported Request) on a read passes with reason 01 and all-ones data, lane-aligned as in R7. On a write it fails with reason 01.
- R5: Code 100 (Completer Abort) fails with reason 10 for both reads and writes. Codes 011, 101, 110 and 111 fail with reason 11.
- R6: Every failed result carries `rdata` = 0xFFFFFFFF, and every write result carries 0xFFFFFFFF.
- R7: Read data is aligned to its lane. For a byte read, `rdata` is `(d >> 8*lo) & 0xFF`. For a halfword read it is `(d >> 8*lo) & 0xFFFF`. A dword read returns `d` unchanged.
- R8: Code 010 (retry) with `crs_vis_en` = 1 on a read of dword 0, byte offset 0, halfword or dword size, passes with reason 00. The data is 0x0001 for a halfword read and 0xFFFF0001 for a dword read.
- R9: Any other code-010 completion re-issues the request, with `lnk_launch` set in the next cycle, as long as fewer than `retry_max` re-issues have been made. Once that cap is reached, the request fails with reason 11. A cap of 0 fails on the first retry completion.
- R10: If no completion has arrived by the time the timer reaches `tmo_cycles`, `done` rises `tmo_cycles`+1 cycles after the launch cycle. A completion that arrives in the cycle the timer reaches `tmo_cycles` is still accepted. On a timeout, a read of dword 0 at byte offset 0 passes with 0xFFFF0001 and reason 11. Any other access fails.
- R11: After a timeout, each request is answered in the next cycle by the R10 rule, without a launch. The late completion produces no `done` and returns the block to normal operation.
- R12: `done` is a one-cycle pulse for each answered request. `pass`, `reason` and `rdata` hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = configuration write |
| req_dw | input | DW_W | Dword offset |
| req_lo | input | 2 | Byte offset within the dword |
| req_sz | input | 2 | Size code: 00 byte, 01 halfword, 1x dword |
| crs_vis_en | input | 1 | Retry visibility enable |
| retry_max | input | RC_W | Maximum number of re-issues |
| tmo_cycles | input | TM_W | Completion timeout in cycles |
| lnk_launch | output | 1 | Launch pulse toward the link |
| lnk_write | output | 1 | Direction of the launched request |
| lnk_dw | output | DW_W | Dword offset of the launched request |
| lnk_be | output | 4 | Byte enables of the launched request |
| cpl_valid | input | 1 | Completion strobe |
| cpl_code | input | 3 | Completion status word bits 9:7 |
| cpl_err | input | 1 | Completion status word bit 11 |
| cpl_data | input | 32 | Completion data |
| done | output | 1 | Result pulse |
| pass | output | 1 | Result: 1 = success |
| reason | output | 2 | 00 OK, 01 UR, 10 CA, 11 other or timeout |
| rdata | output | 32 | Read data seen by the host |

## Verification
The first sweep covers every non-retry status code, both values of the error flag, both directions, and every byte offset with every size. It separates the success path from the error flag, the direction-dependent Unsupported Request rule, and the per-lane shift and mask. The retry tests change visibility, Vendor ID coverage, access size and the retry cap. These show the fabricated-value path apart from the re-issue path, and they find the exact point at which the cap stops re-issuing. The timeout tests deliver a completion in the last cycle it can be accepted and withhold one entirely. They then send Vendor ID and other requests while the late completion is still outstanding, and finally release it.

// File: rtl/cfg_cpl_pkg.sv
package cfg_cpl_pkg;
  typedef enum logic [1:0] {RSN_OK = 2'd0, RSN_UR = 2'd1, RSN_CA = 2'd2, RSN_OTHER = 2'd3} reason_t;
  typedef enum logic [1:0] {ACT_DATA, ACT_FAB, ACT_FAIL, ACT_RETRY} act_t;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_STALE} state_t;
  localparam logic [2:0]  CODE_SC   = 3'b000;
  localparam logic [2:0]  CODE_UR   = 3'b001;
  localparam logic [2:0]  CODE_RTY  = 3'b010;
  localparam logic [2:0]  CODE_CA   = 3'b100;
  localparam logic [31:0] ALL_ONES  = 32'hFFFF_FFFF;
  localparam logic [31:0] VID_RETRY = 32'hFFFF_0001;
endpackage

// File: rtl/cfg_lane_align.sv
module cfg_lane_align (
  input  logic [31:0] din,
  input  logic [1:0]  lo,
  input  logic [1:0]  sz,
  output logic [31:0] dout,
  output logic [3:0]  be
);
  logic [15:0] win;

  always_comb begin
    case (lo)
      2'd0:    win = din[15:0];
      2'd1:    win = din[23:8];
      2'd2:    win = din[31:16];
      default: win = {8'h00, din[31:24]};
    endcase
  end

  always_comb begin
    case (sz)
      2'b00: begin
        dout = {24'h0, win[7:0]};
        be   = 4'b0001 << lo;
      end
      2'b01: begin
        dout = {16'h0, win};
        be   = 4'b0011 << lo;
      end
      default: begin
        dout = din;
        be   = 4'b1111;
      end
    endcase
  end
endmodule

// File: rtl/cfg_cpl_decode.sv
module cfg_cpl_decode
  import cfg_cpl_pkg::*;
(
  input  logic        [2:0]  code,
  input  logic               err,
  input  logic               is_write,
  input  logic               vis_en,
  input  logic               vid_cover,
  output act_t               act,
  output reason_t            rsn,
  output logic        [31:0] fab
);
  always_comb begin
    act = ACT_FAIL;
    rsn = RSN_OTHER;
    fab = ALL_ONES;
    case (code)
      CODE_SC: begin
        if (!err) begin
          act = ACT_DATA;
          rsn = RSN_OK;
        end
      end
      CODE_UR: begin
        rsn = RSN_UR;
        if (!is_write) act = ACT_FAB;
      end
      CODE_RTY: begin
        if (!is_write && vis_en && vid_cover) begin
          act = ACT_FAB;
          rsn = RSN_OK;
          fab = VID_RETRY;
        end else begin
          act = ACT_RETRY;
        end
      end
      CODE_CA: rsn = RSN_CA;
      default: ;
    endcase
  end
endmodule

// File: rtl/cfg_cpl_timer.sv
module cfg_cpl_timer #(
  parameter int TM_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            en,
  input  logic [TM_W-1:0] limit,
  output logic            expire
);
  logic [TM_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)              cnt <= '0;
    else if (en && cnt != limit) cnt <= cnt + 1'b1;
  end

  assign expire = en && (cnt == limit);
endmodule

// File: rtl/cfg_cpl_handler.sv
module cfg_cpl_handler
  import cfg_cpl_pkg::*;
#(
  parameter int DW_W = 10,
  parameter int RC_W = 4,
  parameter int TM_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [DW_W-1:0] req_dw,
  input  logic [1:0]      req_lo,
  input  logic [1:0]      req_sz,
  input  logic            crs_vis_en,
  input  logic [RC_W-1:0] retry_max,
  input  logic [TM_W-1:0] tmo_cycles,
  output logic            lnk_launch,
  output logic            lnk_write,
  output logic [DW_W-1:0] lnk_dw,
  output logic [3:0]      lnk_be,
  input  logic            cpl_valid,
  input  logic [2:0]      cpl_code,
  input  logic            cpl_err,
  input  logic [31:0]     cpl_data,
  output logic            done,
  output logic            pass,
  output logic [1:0]      reason,
  output logic [31:0]     rdata
);
  state_t          st, nx_st;
  logic [1:0]      r_lo, r_sz;
  logic [RC_W-1:0] rcnt;
  act_t            act;
  reason_t         rsn, nx_rsn;
  logic [31:0]     fab, lane_in, aligned, nx_data;
  logic            nx_done, nx_pass, retry_go, go, expire;
  logic            vid_cover, vid_r, vid_q;
  logic            in_idle, in_wait, in_stale;

  assign in_idle  = (st == ST_IDLE);
  assign in_wait  = (st == ST_WAIT);
  assign in_stale = (st == ST_STALE);

  assign vid_r     = !lnk_write && (lnk_dw == '0) && (r_lo == 2'd0);
  assign vid_q     = !req_write && (req_dw == '0) && (req_lo == 2'd0);
  assign vid_cover = vid_r && (r_sz != 2'b00);

  cfg_cpl_decode u_dec (
    .code(cpl_code), .err(cpl_err), .is_write(lnk_write), .vis_en(crs_vis_en),
    .vid_cover(vid_cover), .act(act), .rsn(rsn), .fab(fab)
  );

  assign lane_in = (act == ACT_FAB) ? fab : cpl_data;

  cfg_lane_align u_lane (
    .din(lane_in), .lo(r_lo), .sz(r_sz), .dout(aligned), .be(lnk_be)
  );

  cfg_cpl_timer #(.TM_W(TM_W)) u_tmr (
    .clk(clk), .rst(rst), .clr(go), .en(in_wait), .limit(tmo_cycles), .expire(expire)
  );

  always_comb begin
    nx_st    = st;
    nx_done  = 1'b0;
    nx_pass  = 1'b0;
    nx_rsn   = RSN_OTHER;
    nx_data  = ALL_ONES;
    retry_go = 1'b0;
    case (st)
      ST_IDLE: if (req_valid) nx_st = ST_WAIT;
      ST_WAIT: begin
        if (cpl_valid) begin
          case (act)
            ACT_DATA, ACT_FAB: begin
              nx_done = 1'b1;
              nx_pass = 1'b1;
              nx_rsn  = rsn;
              nx_data = lnk_write ? ALL_ONES : aligned;
              nx_st   = ST_IDLE;
            end
            ACT_FAIL: begin
              nx_done = 1'b1;
              nx_rsn  = rsn;
              nx_st   = ST_IDLE;
            end
            default: begin
              if (rcnt == retry_max) begin
                nx_done = 1'b1;
                nx_st   = ST_IDLE;
              end else begin
                retry_go = 1'b1;
              end
            end
          endcase
        end else if (expire) begin
          nx_done = 1'b1;
          nx_pass = vid_r;
          nx_data = vid_r ? VID_RETRY : ALL_ONES;
          nx_st   = ST_STALE;
        end
      end
      ST_STALE: begin
        if (req_valid) begin
          nx_done = 1'b1;
          nx_pass = vid_q;
          nx_data = vid_q ? VID_RETRY : ALL_ONES;
        end
        if (cpl_valid) nx_st = ST_IDLE;
      end
      default: nx_st = ST_IDLE;
    endcase
  end

  assign go = (in_idle && req_valid) || retry_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      lnk_launch <= 1'b0;
      lnk_write  <= 1'b0;
      lnk_dw     <= '0;
      r_lo       <= 2'd0;
      r_sz       <= 2'd0;
      rcnt       <= '0;
      done       <= 1'b0;
      pass       <= 1'b0;
      reason     <= RSN_OK;
      rdata      <= '0;
    end else begin
      st         <= nx_st;
      lnk_launch <= go;
      done       <= nx_done;
      if (in_idle && req_valid) begin
        lnk_write <= req_write;
        lnk_dw    <= req_dw;
        r_lo      <= req_lo;
        r_sz      <= req_sz;
        rcnt      <= '0;
      end else if (retry_go) begin
        rcnt <= rcnt + 1'b1;
      end
      if (nx_done) begin
        pass   <= nx_pass;
        reason <= nx_rsn;
        rdata  <= nx_data;
      end
    end
  end
endmodule

// File: rtl/cfg_cpl_handler_chk.sv
module cfg_cpl_handler_chk #(
  parameter int RC_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            in_idle,
  input logic            in_wait,
  input logic            in_stale,
  input logic            cpl_valid,
  input logic [2:0]      cpl_code,
  input logic            lnk_write,
  input logic            lnk_launch,
  input logic [RC_W-1:0] rcnt,
  input logic [RC_W-1:0] retry_max,
  input logic            done,
  input logic            pass,
  input logic [1:0]      reason,
  input logic [31:0]     rdata
);
  AST_LAUNCH_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    (in_idle && req_valid) |=> lnk_launch); // R2
  AST_WR_UR_FAIL: assert property (@(posedge clk) disable iff (rst)
    (in_wait && cpl_valid && lnk_write && cpl_code == 3'b001) |=> (done && !pass && reason == 2'd1)); // R4
  AST_CA_FAIL: assert property (@(posedge clk) disable iff (rst)
    (in_wait && cpl_valid && cpl_code == 3'b100) |=> (done && !pass && reason == 2'd2)); // R5
  AST_FAIL_ONES: assert property (@(posedge clk) disable iff (rst)
    (done && !pass) |-> (rdata == 32'hFFFF_FFFF)); // R6
  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (rst)
    in_wait |-> (rcnt <= retry_max)); // R9
  AST_STALE_NO_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    in_stale |=> !lnk_launch); // R11
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rdata)); // R12
endmodule

bind cfg_cpl_handler cfg_cpl_handler_chk #(.RC_W(RC_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .in_idle(in_idle), .in_wait(in_wait),
  .in_stale(in_stale), .cpl_valid(cpl_valid), .cpl_code(cpl_code), .lnk_write(lnk_write),
  .lnk_launch(lnk_launch), .rcnt(rcnt), .retry_max(retry_max), .done(done), .pass(pass),
  .reason(reason), .rdata(rdata)
);

// File: tb/cfg_cpl_handler_bench.sv
`timescale 1ns/1ps
module cfg_cpl_handler_bench;
  localparam int DW_W = 10, RC_W = 4, TM_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_write = 0;
  logic [DW_W-1:0] req_dw = '0;
  logic [1:0] req_lo = 0, req_sz = 0;
  logic crs_vis_en = 0;
  logic [RC_W-1:0] retry_max = 0;
  logic [TM_W-1:0] tmo_cycles = 16'd100;
  logic lnk_launch, lnk_write;
  logic [DW_W-1:0] lnk_dw;
  logic [3:0] lnk_be;
  logic cpl_valid = 0;
  logic [2:0] cpl_code = 0;
  logic cpl_err = 0;
  logic [31:0] cpl_data = 0;
  logic done, pass;
  logic [1:0] reason;
  logic [31:0] rdata;

  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  cfg_cpl_handler #(.DW_W(DW_W), .RC_W(RC_W), .TM_W(TM_W)) u_cfg_cpl_handler (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_dw(req_dw),
    .req_lo(req_lo), .req_sz(req_sz), .crs_vis_en(crs_vis_en), .retry_max(retry_max),
    .tmo_cycles(tmo_cycles), .lnk_launch(lnk_launch), .lnk_write(lnk_write), .lnk_dw(lnk_dw),
    .lnk_be(lnk_be), .cpl_valid(cpl_valid), .cpl_code(cpl_code), .cpl_err(cpl_err),
    .cpl_data(cpl_data), .done(done), .pass(pass), .reason(reason), .rdata(rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Results read at a negedge, one cycle after the deciding posedge.
  task automatic check_res(input string tag, input logic ep, input logic [1:0] er, input logic [31:0] ed);
    check({tag, " done"}, {31'd0, done}, 32'd1);
    check({tag, " pass"}, {31'd0, pass}, {31'd0, ep});
    check({tag, " reason"}, {30'd0, reason}, {30'd0, er});
    check({tag, " rdata"}, rdata, ed);
  endtask

  task automatic send_req(input logic w, input logic [DW_W-1:0] dw, input logic [1:0] lo, input logic [1:0] sz);
    @(negedge clk);
    req_write = w; req_dw = dw; req_lo = lo; req_sz = sz; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Status word layout: code in bits 9:7, error flag in bit 11.
  task automatic send_cpl(input logic [31:0] sword, input logic [31:0] d);
    cpl_code = sword[9:7]; cpl_err = sword[11]; cpl_data = d; cpl_valid = 1'b1;
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  function automatic logic [31:0] swd(input logic [2:0] code, input logic err);
    return 32'hA000_0035 | ({31'd0, err} << 11) | ({29'd0, code} << 7);
  endfunction

  function automatic logic [31:0] lane(input logic [31:0] d, input logic [1:0] lo, input logic [1:0] sz);
    logic [31:0] s;
    s = d >> (8 * lo);
    if (sz == 2'b00) return s & 32'h0000_00FF;
    if (sz == 2'b01) return s & 32'h0000_FFFF;
    return d;
  endfunction

  function automatic logic [3:0] exp_be(input logic [1:0] lo, input logic [1:0] sz);
    if (sz == 2'b00) return 4'(1 << lo);
    if (sz == 2'b01) return 4'(3 << lo);
    return 4'hF;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int idx;
    logic ep;
    logic [1:0] er;
    logic [31:0] ed, d;
    string tag;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 done", {31'd0, done}, 0);
    check("R1 pass", {31'd0, pass}, 0);
    check("R1 launch", {31'd0, lnk_launch}, 0);
    check("R1 reason", {30'd0, reason}, 0);
    check("R1 rdata", rdata, 0);

    // Sweep all non-retry codes, error flag, direction, lane and size
    idx = 0;
    for (int w = 0; w < 2; w++)
      for (int c = 0; c < 8; c++) begin
        if (c == 2) continue;
        for (int e = 0; e < 2; e++)
          for (int lo = 0; lo < 4; lo++)
            for (int sz = 0; sz < 3; sz++) begin
              d = 32'h1357_9BDF + idx * 32'h0F1E_2D3C;
              idx++;
              send_req(w[0], 10'd3 + 10'(lo), lo[1:0], sz[1:0]);
              check("R2 launch", {31'd0, lnk_launch}, 1);
              check("R2 be", {28'd0, lnk_be}, {28'd0, exp_be(lo[1:0], sz[1:0])});
              check("R2 dw", {22'd0, lnk_dw}, 32'd3 + 32'(lo));
              check("R2 write", {31'd0, lnk_write}, {31'd0, w[0]});
              if (c == 0 && e == 0) begin
                ep = 1; er = 0; ed = w ? 32'hFFFF_FFFF : lane(d, lo[1:0], sz[1:0]);
                tag = w ? "R3/R6 write ok" : "R3/R7 read ok";
              end else if (c == 0) begin
                ep = 0; er = 3; ed = 32'hFFFF_FFFF; tag = "R3 error flag";
              end else if (c == 1) begin
                ep = !w; er = 1;
                ed = w ? 32'hFFFF_FFFF : lane(32'hFFFF_FFFF, lo[1:0], sz[1:0]);
                tag = "R4 unsupported";
              end else if (c == 4) begin
                ep = 0; er = 2; ed = 32'hFFFF_FFFF; tag = "R5 abort";
              end else begin
                ep = 0; er = 3; ed = 32'hFFFF_FFFF; tag = "R5 unknown";
              end
              send_cpl(swd(c[2:0], e[0]), d);
              check_res(tag, ep, er, ed);
              @(negedge clk);
              check("R12 pulse", {31'd0, done}, 0);
              check("R12 hold", rdata, ed);
            end
      end

    // Retry without visibility: cap of 2 re-issues
    crs_vis_en = 0; retry_max = 2;
    send_req(0, 0, 0, 2'b10);
    send_cpl(swd(2, 0), 0);
    check("R9 relaunch 1", {31'd0, lnk_launch}, 1);
    check("R9 no done 1", {31'd0, done}, 0);
    send_cpl(swd(2, 0), 0);
    check("R9 relaunch 2", {31'd0, lnk_launch}, 1);
    send_cpl(swd(2, 0), 0);
    check("R9 cap launch", {31'd0, lnk_launch}, 0);
    check_res("R9 cap fail", 0, 3, 32'hFFFF_FFFF);

    // Write retried then completes
    send_req(1, 4, 0, 2'b10);
    send_cpl(swd(2, 0), 0);
    check("R9 write relaunch", {31'd0, lnk_launch}, 1);
    send_cpl(swd(0, 0), 32'h1234_5678);
    check_res("R9 write after retry", 1, 0, 32'hFFFF_FFFF);

    // Cap of zero
    retry_max = 0;
    send_req(0, 4, 0, 2'b10);
    send_cpl(swd(2, 0), 0);
    check("R9 cap0 launch", {31'd0, lnk_launch}, 0);
    check_res("R9 cap0 fail", 0, 3, 32'hFFFF_FFFF);

    // Visibility enabled
    crs_vis_en = 1; retry_max = 1;
    send_req(0, 0, 0, 2'b01);
    send_cpl(swd(2, 0), 32'h5555_5555);
    check_res("R8 half vid", 1, 0, 32'h0000_0001);
    send_req(0, 0, 0, 2'b10);
    send_cpl(swd(2, 0), 32'h5555_5555);
    check_res("R8 word vid", 1, 0, 32'hFFFF_0001);
    send_req(0, 0, 0, 2'b00);
    send_cpl(swd(2, 0), 0);
    check("R9 byte vid relaunch", {31'd0, lnk_launch}, 1);
    send_cpl(swd(2, 0), 0);
    check_res("R9 byte vid cap", 0, 3, 32'hFFFF_FFFF);
    send_req(0, 0, 2, 2'b01);
    send_cpl(swd(2, 0), 0);
    check("R9 other read relaunch", {31'd0, lnk_launch}, 1);
    send_cpl(swd(0, 0), 32'hCAFE_BEEF);
    check_res("R9/R7 other read data", 1, 0, 32'h0000_CAFE);
    send_req(1, 0, 0, 2'b10);
    send_cpl(swd(2, 0), 0);
    check("R9 write vis relaunch", {31'd0, lnk_launch}, 1);
    send_cpl(swd(0, 0), 0);
    check_res("R9 write vis ok", 1, 0, 32'hFFFF_FFFF);

    // Timeout boundary: completion in cycle timer reaches limit
    tmo_cycles = 5;
    send_req(0, 7, 0, 2'b10);
    repeat (5) @(negedge clk);
    send_cpl(swd(0, 0), 32'h0BAD_F00D);
    check_res("R10 last cycle accepted", 1, 0, 32'h0BAD_F00D);

    // Vendor read times out
    send_req(0, 0, 0, 2'b10);
    idx = 0;
    while (!done && idx < 50) begin
      @(negedge clk);
      idx++;
    end
    check("R10 latency", idx, 6);
    check_res("R10 vid timeout", 1, 3, 32'hFFFF_0001);

    // Stale: requests answered without launch
    send_req(0, 5, 0, 2'b10);
    check("R11 no launch", {31'd0, lnk_launch}, 0);
    check_res("R11 stale other", 0, 3, 32'hFFFF_FFFF);
    send_req(0, 0, 0, 2'b01);
    check_res("R11 stale vid", 1, 3, 32'hFFFF_0001);
    @(negedge clk);
    send_cpl(swd(0, 0), 32'h7777_7777);
    check("R11 late drop", {31'd0, done}, 0);
    send_req(0, 6, 1, 2'b00);
    check("R11 resume launch", {31'd0, lnk_launch}, 1);
    send_cpl(swd(0, 0), 32'h00AB_CD00);
    check_res("R11 resume data", 1, 0, 32'h0000_00CD);

    // Write times out
    send_req(1, 0, 0, 2'b10);
    idx = 0;
    while (!done && idx < 50) begin
      @(negedge clk);
      idx++;
    end
    check("R10 write latency", idx, 6);
    check_res("R10 write timeout", 0, 3, 32'hFFFF_FFFF);
    send_cpl(swd(0, 0), 0);
    check("R11 write late drop", {31'd0, done}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule